// File: doc/BRIEF.md
# Iterative Feedback Symbol Encoder

The block turns a frame of twelve 3-bit message symbols into a 24-bit code word and a 3-bit closing tuple. Each accepted symbol passes through a fixed 16-entry lookup along with a one-bit selector. The lookup gives three bits. The first two are shifted into the code word. The third is kept in a register and becomes the selector for the next symbol. One symbol is handled per clock, and the block is meant for a 24 MHz clock.

A start pulse opens a frame. It clears the selector, the code word and the closing tuple. Symbols are then offered with a valid strobe, and gaps are allowed. After the last accepted symbol of the frame, the block raises a one-cycle done pulse. The code word and the closing tuple then stay as they are until the next start.

Top module: `fbk_sym_encoder`

## Requirements
- R1: With selector 0, the lookup ignores M1 (sym_i[2]) and maps M2 M3 (sym_i[1:0]) to {bit1,bit2,bit3} as follows: 00→000, 01→101, 10→110, 11→011.
- R2: With selector 1, the lookup maps M1 M2 M3 (sym_i[2:0]) to {bit1,bit2,bit3} as follows: 000→001, 001→001, 010→010, 011→010, 100→100, 101→111, 110→100, 111→111.
- R3: Reset and every start pulse clear the selector, so the first symbol of a frame always uses selector 0.
- R4: The bit3 of each accepted symbol, except the last one, is the selector for the next accepted symbol.
- R5: Each accepted symbol shifts {bit1,bit2} into result_o from the right. The first symbol's bit1 therefore ends at bit 23 and the last symbol's bit2 at bit 0.
- R6: A symbol is accepted only on a cycle where sym_valid_i is high, a frame is open and start_i is low. A frame closes after exactly STEPS accepted symbols (12 by default).
- R7: done_o is high for exactly one cycle, on the cycle after the clock edge that accepts the last symbol of the frame.
- R8: On the clock edge that accepts the last symbol, final_o is loaded with that symbol's {bit1,bit2,bit3}, with bit1 at bit 2.
- R9: Outside an open frame, symbols have no effect. result_o and final_o hold and done_o stays low until the next start.
- R10: After reset, result_o, final_o and done_o are all zero.
- R11: A start pulse, even one that arrives during an open frame, clears result_o and final_o to zero and restarts the step count. A symbol that is valid on the start cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a new frame |
| sym_i | input | 3 | Message symbol {M1,M2,M3} |
| sym_valid_i | input | 1 | sym_i is offered this cycle |
| result_o | output | 2*STEPS | Code word built from the {bit1,bit2} pairs |
| final_o | output | 3 | {bit1,bit2,bit3} of the last step |
| done_o | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench builds the block twice. The first instance uses the default STEPS=12. It runs many full frames with varied symbol streams, valid gaps, restarts in the middle of a frame, and symbols sent while idle. This puts the feedback chain, the packing order and the done timing within reach over a whole frame. The second instance uses STEPS=2. Its first symbol forces the selector to a chosen value, so a sweep of the second symbol reaches all 16 lookup entries directly through final_o.

// File: rtl/fse_pkg.sv
package fse_pkg;

  // Output triple is {bit1, bit2, bit3}; symbol is {M1, M2, M3}.
  function automatic logic [2:0] fse_lookup(input logic sel, input logic [2:0] m);
    logic [2:0] r;
    case ({sel, m})
      4'b0000: r = 3'b000;
      4'b0001: r = 3'b101;
      4'b0010: r = 3'b110;
      4'b0011: r = 3'b011;
      4'b0100: r = 3'b000;
      4'b0101: r = 3'b101;
      4'b0110: r = 3'b110;
      4'b0111: r = 3'b011;
      4'b1000: r = 3'b001;
      4'b1001: r = 3'b001;
      4'b1010: r = 3'b010;
      4'b1011: r = 3'b010;
      4'b1100: r = 3'b100;
      4'b1101: r = 3'b111;
      4'b1110: r = 3'b100;
      default: r = 3'b111;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fse_step_map.sv
module fse_step_map
  import fse_pkg::*;
(
  input  logic       sel,
  input  logic [2:0] sym,
  output logic [2:0] step_out
);
  always_comb step_out = fse_lookup(sel, sym);
endmodule

// File: rtl/fse_frame_ctrl.sv
module fse_frame_ctrl #(
  parameter int STEPS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic valid,
  output logic busy,
  output logic accept,
  output logic last,
  output logic done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign accept = busy_q & valid & ~start;
  assign last   = accept & (cnt_q == LAST_IDX);
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (start) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (accept) begin
        if (last) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fse_datapath.sv
module fse_datapath #(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             accept,
  input  logic             last,
  input  logic [2:0]       step_out,
  output logic             sel,
  output logic [RES_W-1:0] result,
  output logic [2:0]       final_t
);
  logic             sel_q;
  logic [RES_W-1:0] res_q;
  logic [2:0]       fin_q;

  assign sel     = sel_q;
  assign result  = res_q;
  assign final_t = fin_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      sel_q <= 1'b0;
      res_q <= '0;
      fin_q <= '0;
    end else if (accept) begin
      res_q <= RES_W'({res_q, step_out[2:1]});
      sel_q <= step_out[0];
      if (last) fin_q <= step_out;
    end
  end
endmodule

// File: rtl/fbk_sym_encoder.sv
module fbk_sym_encoder #(
  parameter int STEPS = 12,
  localparam int RES_W = 2 * STEPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       sym_i,
  input  logic             sym_valid_i,
  output logic [RES_W-1:0] result_o,
  output logic [2:0]       final_o,
  output logic             done_o
);
  logic       busy_w;
  logic       accept_w;
  logic       last_w;
  logic       sel_w;
  logic [2:0] step_w;

  fse_frame_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .valid(sym_valid_i),
    .busy(busy_w), .accept(accept_w), .last(last_w), .done(done_o)
  );

  fse_step_map u_map (.sel(sel_w), .sym(sym_i), .step_out(step_w));

  fse_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rst(rst), .start(start_i), .accept(accept_w), .last(last_w),
    .step_out(step_w), .sel(sel_w), .result(result_o), .final_t(final_o)
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             accept,
  input logic             last,
  input logic             busy,
  input logic             sel,
  input logic [2:0]       step_out,
  input logic [RES_W-1:0] result,
  input logic [2:0]       final_t,
  input logic             done
);
  a_r3_start_clears_sel: assert property (@(posedge clk) disable iff (rst)
    start |=> (sel == 1'b0) && busy);

  a_r4_feedback: assert property (@(posedge clk) disable iff (rst)
    accept && !last |=> sel == $past(step_out[0]));

  a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
    accept |=> result[1:0] == $past(step_out[2:1]));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(last));

  a_r8_final_tuple: assert property (@(posedge clk) disable iff (rst)
    last |=> final_t == $past(step_out));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(result) && $stable(final_t));

  a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (result == '0) && (final_t == 3'b000));
endmodule

bind fbk_sym_encoder fse_checker #(.RES_W(RES_W)) u_fse_chk (
  .clk(clk), .rst(rst), .start(start_i), .accept(accept_w), .last(last_w),
  .busy(busy_w), .sel(sel_w), .step_out(step_w), .result(result_o),
  .final_t(final_o), .done(done_o)
);

// File: tb/test_fbk_sym_encoder.sv
module test_fbk_sym_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start_i = 1'b0, sym_valid_i = 1'b0;
  logic [2:0]  sym_i = '0;
  logic [23:0] result_o;
  logic [2:0]  final_o;
  logic        done_o;

  logic        s2_start = 1'b0, s2_valid = 1'b0;
  logic [2:0]  s2_sym = '0;
  logic [3:0]  s2_result;
  logic [2:0]  s2_final;
  logic        s2_done;

  int n_chk = 0, n_fail = 0, cycles = 0;

  fbk_sym_encoder i_fbk_sym_encoder (
    .clk(clk), .rst(rst), .start_i(start_i), .sym_i(sym_i),
    .sym_valid_i(sym_valid_i), .result_o(result_o), .final_o(final_o), .done_o(done_o)
  );

  fbk_sym_encoder #(.STEPS(2)) i_fbk_sym_encoder_s2 (
    .clk(clk), .rst(rst), .start_i(s2_start), .sym_i(s2_sym),
    .sym_valid_i(s2_valid), .result_o(s2_result), .final_o(s2_final), .done_o(s2_done)
  );

  // Reference written as boolean equations, returning {bit1,bit2,bit3}.
  function automatic logic [2:0] ref_map(input logic s, input logic [2:0] m);
    logic b1, b2, b3;
    b1 = s ? m[2] : (m[1] ^ m[0]);
    b2 = s ? (m[2] ? m[0] : m[1]) : m[1];
    b3 = s ? (m[2] ? m[0] : ~m[1]) : m[0];
    return {b1, b2, b3};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic send(input logic [2:0] s);
    sym_i = s; sym_valid_i = 1'b1;
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  task automatic run_frame(input int seed, input bit gaps);
    logic        sel_m;
    logic [23:0] res_m;
    logic [2:0]  o, last_o;
    start_i = 1'b1;
    if (gaps) begin sym_i = 3'b111; sym_valid_i = 1'b1; end
    @(negedge clk);
    start_i = 1'b0; sym_valid_i = 1'b0;
    chk("R11 start clears result", 32'(result_o), 32'h0);
    chk("R11 start clears final", 32'(final_o), 32'h0);
    sel_m = 1'b0; res_m = '0; last_o = '0;
    for (int k = 0; k < 12; k++) begin
      logic [2:0] s;
      s = 3'((k * (seed | 1) + seed + k / 3) % 8);
      if (gaps && k == 5) begin
        for (int g = 0; g < 2; g++) begin sym_i = ~s; @(negedge clk); end
        chk("R6 gap does not advance", 32'(result_o), 32'(res_m));
      end
      chk("R7 no early done", 32'(done_o), 32'h0);
      send(s);
      o = ref_map(sel_m, s);
      res_m = {res_m[21:0], o[2:1]};
      sel_m = o[0];
      last_o = o;
      chk("R4/R5 result after step", 32'(result_o), 32'(res_m));
    end
    chk("R7 done after last step", 32'(done_o), 32'h1);
    chk("R8 final tuple", 32'(final_o), 32'(last_o));
    @(negedge clk);
    chk("R7 done one cycle", 32'(done_o), 32'h0);
    for (int k = 0; k < 3; k++) send(3'(k + 5));
    chk("R9 idle result held", 32'(result_o), 32'(res_m));
    chk("R9 idle final held", 32'(final_o), 32'(last_o));
    chk("R9 idle no done", 32'(done_o), 32'h0);
  endtask

  task automatic s2_entry(input logic s, input logic [2:0] m);
    logic [2:0] first, o1, o2;
    first = s ? 3'b001 : 3'b000;
    s2_start = 1'b1; @(negedge clk); s2_start = 1'b0;
    s2_sym = first; s2_valid = 1'b1; @(negedge clk);
    s2_sym = m; @(negedge clk); s2_valid = 1'b0;
    o1 = ref_map(1'b0, first);
    o2 = ref_map(o1[0], m);
    if (s) chk("R2 lookup sel=1", 32'(s2_final), 32'(o2));
    else   chk("R1 lookup sel=0", 32'(s2_final), 32'(o2));
    chk("R5 s2 packing", 32'(s2_result), 32'({o1[2:1], o2[2:1]}));
    chk("R7 s2 done", 32'(s2_done), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 reset result", 32'(result_o), 32'h0);
    chk("R10 reset final", 32'(final_o), 32'h0);
    chk("R10 reset done", 32'(done_o), 32'h0);

    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++) s2_entry(s[0], 3'(m));

    run_frame(1, 1'b1);
    // restart in the middle of a frame (R6, R11, R3)
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 5; k++) send(3'b001);
    run_frame(3, 1'b0);
    for (int f = 0; f < 24; f++) run_frame(f * 7 + 2, f[0]);
    finish_run();
  end
endmodule